// File: doc/BRIEF.md
# CAN Bit-Timing Solver

This block turns a requested bus bit rate into the three numbers a CAN controller's bit-timing register needs: the clock prescaler and the lengths, in time quanta, of the segment before the sample point and the segment after it. The caller presents the input clock frequency and the bit rate, both in hertz as plain integers, and pulses `start_i`. The block then works out how many quanta fit in one bit. It walks through every allowed first-segment length and keeps the split whose two halves are closest in length. Last, it derives the prescaler by a division that rounds up.

A single shift-subtract divider does all four divisions in turn, so the block is small and takes a few hundred cycles. The result comes out as one packed word in which each field holds its value minus one, ready to be written into a controller. A one-cycle `done_o` pulse marks a new result. When no legal setting exists, the same pulse comes with `err_o` set and a zero word. Both the word and the error flag hold their values until the next result.

Top module: `bt_timing_solver`

## Requirements
- R1: During and directly after reset, `busy_o`, `done_o` and `err_o` are 0 and `timing_o` is all zeros.
- R2: The result word packs prescaler−1 in bits [9:0], first segment−1 in bits [13:10], second segment−1 in bits [16:14], and the resynchronisation jump width code 0 (a width of one quantum) in bits [18:17].
- R3: The quanta total is (clock / 3) / rate − 1, using integer division at each step. First-segment candidates run from 1 to 16 in rising order, and the second segment is the total minus the candidate. The walk stops at the first candidate whose second segment is below 1. A candidate whose second segment is above 8 is passed over, and the walk goes on.
- R4: Of the legal candidates, the block keeps the one with the smallest absolute difference between the two segments. A later candidate replaces the kept one only if its difference is strictly smaller, so on a tie the lower first segment wins.
- R5: If no candidate is legal, `err_o` is raised with the done pulse.
- R6: The prescaler is ceil((clock / (first + second + 1)) / rate). A prescaler above the parameter `PRE_MAX` (default 1024), or a prescaler of zero, raises `err_o`.
- R7: A rate of zero produces `done_o` with `err_o` set on the clock edge that accepts the start. No division runs, and `busy_o` stays low.
- R8: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle. `timing_o` and `err_o` change only in a cycle in which `done_o` is high.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored. The result of the run in progress is unaffected.
- R10: With the default parameters, a 42,000,000 Hz clock and a rate of 1,000,000 give first segment 6, second segment 7 and prescaler 3, so `timing_o` = 103426.
- R11: Whenever `err_o` is set, `timing_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins a solve; accepted only while idle |
| clk_hz_i | input | FREQ_W | Input clock frequency in Hz |
| baud_i | input | FREQ_W | Requested bit rate in bits per second |
| busy_o | output | 1 | A solve is in progress |
| done_o | output | 1 | One-cycle pulse: result or error is valid |
| err_o | output | 1 | No legal setting was found for the last request |
| timing_o | output | WORD_W | Packed timing word, each field holding its value minus one |

## Verification
Every internal fault in this block shows at the ports within one solve. A corrupted quotient, a wrong candidate counter or a stale best-difference register gives a wrong field in `timing_o`, or a wrong `err_o`, on the done pulse that closes that request. Sequencing faults show as well: a stuck phase, a lost divider handshake or a start accepted while busy. These give a done pulse that never comes, a pulse that comes when none is due, or a change on the output between pulses, and the per-clock comparison catches each one in the cycle it happens. The stimulus is chosen to reach the search corners: ties, candidates passed over, an early stop, the largest legal total and the prescaler limit.

// File: rtl/bt_solver_pkg.sv
package bt_solver_pkg;

   // Sequencing phases of the solver
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_DIV3 = 3'd1,   // clock / 3
      PH_DIVB = 3'd2,   // (clock / 3) / rate
      PH_SRCH = 3'd3,   // segment search
      PH_DIVN = 3'd4,   // clock / (s1 + s2 + 1)
      PH_DIVR = 3'd5    // ceil(... / rate)
   } phase_e;

   // Width of the jump-width field; value is fixed at one quantum (code 0)
   localparam int unsigned SJW_W = 2;

endpackage

// File: rtl/bt_div_iter.sv
// Restoring divider, one quotient bit per cycle.
module bt_div_iter #(
   parameter int unsigned W = 33
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         done_o,
   output logic [W-1:0] quo_o
);
   localparam int unsigned CNT_W = $clog2(W + 1);

   logic [W-1:0]     rem_q;
   logic [W-1:0]     quo_q;
   logic [W-1:0]     den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   logic [W:0] rem_sh;
   logic [W:0] trial;

   always_comb begin
      rem_sh = {rem_q, quo_q[W-1]};
      trial  = rem_sh - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i && !run_q) begin
            rem_q <= '0;
            quo_q <= num_i;
            den_q <= den_i;
            cnt_q <= CNT_W'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (!trial[W]) begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= rem_sh[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;

endmodule

// File: rtl/bt_seg_search.sv
// Walks first-segment candidates one per step, keeps the most balanced legal pair.
module bt_seg_search #(
   parameter int unsigned SEG1_MAX = 16,
   parameter int unsigned SEG2_MAX = 8,
   parameter int unsigned TOT_W    = 34,
   parameter int unsigned S1C_W    = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    init_i,
   input  logic                    step_i,
   input  logic signed [TOT_W-1:0] total_i,
   output logic                    fin_o,
   output logic                    found_o,
   output logic [S1C_W-1:0]        s1_o,
   output logic [S1C_W-1:0]        s2_o
);
   logic [S1C_W-1:0] cand_q;
   logic [S1C_W-1:0] best_d_q;
   logic [S1C_W-1:0] best_s1_q;
   logic [S1C_W-1:0] best_s2_q;
   logic             fin_q;

   logic signed [TOT_W-1:0] s2_full;
   logic [S1C_W-1:0]        s2_n;
   logic [S1C_W-1:0]        diff;
   logic                    below, in_rng, better, last;

   always_comb begin
      s2_full = total_i - $signed({{(TOT_W-S1C_W){1'b0}}, cand_q});
      below   = s2_full < $signed(TOT_W'(1));
      in_rng  = !below && (s2_full <= $signed(TOT_W'(SEG2_MAX)));
      s2_n    = s2_full[S1C_W-1:0];
      diff    = (cand_q >= s2_n) ? (cand_q - s2_n) : (s2_n - cand_q);
      better  = in_rng && (diff < best_d_q);
      last    = (cand_q == S1C_W'(SEG1_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q    <= S1C_W'(1);
         best_d_q  <= S1C_W'(SEG1_MAX);
         best_s1_q <= S1C_W'(SEG1_MAX + 1);
         best_s2_q <= '0;
         fin_q     <= 1'b0;
      end else if (init_i) begin
         cand_q    <= S1C_W'(1);
         best_d_q  <= S1C_W'(SEG1_MAX);
         best_s1_q <= S1C_W'(SEG1_MAX + 1);
         best_s2_q <= '0;
         fin_q     <= 1'b0;
      end else if (step_i && !fin_q) begin
         if (below) begin
            fin_q <= 1'b1;
         end else begin
            if (better) begin
               best_d_q  <= diff;
               best_s1_q <= cand_q;
               best_s2_q <= s2_n;
            end
            if (last) fin_q  <= 1'b1;
            else      cand_q <= cand_q + 1'b1;
         end
      end
   end

   assign fin_o   = fin_q;
   assign found_o = (best_s1_q <= S1C_W'(SEG1_MAX));
   assign s1_o    = best_s1_q;
   assign s2_o    = best_s2_q;

endmodule

// File: rtl/bt_timing_solver.sv
module bt_timing_solver
   import bt_solver_pkg::*;
#(
   parameter int unsigned FREQ_W   = 32,
   parameter int unsigned SEG1_MAX = 16,
   parameter int unsigned SEG2_MAX = 8,
   parameter int unsigned PRE_W    = 10,
   parameter int unsigned PRE_MAX  = 1024,
   localparam int unsigned S1_W    = $clog2(SEG1_MAX),
   localparam int unsigned S2_W    = $clog2(SEG2_MAX),
   localparam int unsigned WORD_W  = PRE_W + S1_W + S2_W + SJW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [FREQ_W-1:0] clk_hz_i,
   input  logic [FREQ_W-1:0] baud_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [WORD_W-1:0] timing_o
);
   localparam int unsigned DIV_W = FREQ_W + 1;
   localparam int unsigned TOT_W = DIV_W + 1;
   localparam int unsigned S1C_W = S1_W + 1;

   // Elaboration-time parameter checks
   if (SEG1_MAX < 2 || SEG2_MAX < 2) begin : g_bad_seg
      $error("segment limits must be at least 2");
   end
   if (PRE_MAX < 1 || PRE_MAX > (1 << PRE_W)) begin : g_bad_pre
      $error("PRE_MAX must fit the prescaler field");
   end
   if (FREQ_W < 4) begin : g_bad_freq
      $error("FREQ_W too small");
   end

   phase_e             phase_q;
   logic [FREQ_W-1:0]  freq_q;
   logic [FREQ_W-1:0]  baud_q;
   logic [DIV_W-1:0]   op_a_q;
   logic [DIV_W-1:0]   op_b_q;
   logic               div_go_q;
   logic               div_done;
   logic [DIV_W-1:0]   quot;
   logic signed [TOT_W-1:0] total_q;
   logic               srch_init_q;
   logic               srch_step;
   logic               srch_fin;
   logic               srch_found;
   logic [S1C_W-1:0]   s1_best;
   logic [S1C_W-1:0]   s2_best;
   logic               pre_bad;
   logic [WORD_W-1:0]  word_n;

   bt_div_iter #(.W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go_q),
      .num_i  (op_a_q),
      .den_i  (op_b_q),
      .done_o (div_done),
      .quo_o  (quot)
   );

   assign srch_step = (phase_q == PH_SRCH) && !srch_init_q;

   bt_seg_search #(
      .SEG1_MAX (SEG1_MAX),
      .SEG2_MAX (SEG2_MAX),
      .TOT_W    (TOT_W),
      .S1C_W    (S1C_W)
   ) u_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (srch_init_q),
      .step_i  (srch_step),
      .total_i (total_q),
      .fin_o   (srch_fin),
      .found_o (srch_found),
      .s1_o    (s1_best),
      .s2_o    (s2_best)
   );

   always_comb begin
      pre_bad = (quot == '0) || (quot > DIV_W'(PRE_MAX));
      word_n  = {SJW_W'(0),
                 S2_W'(s2_best - 1'b1),
                 S1_W'(s1_best - 1'b1),
                 PRE_W'(quot - 1'b1)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         freq_q      <= '0;
         baud_q      <= '0;
         op_a_q      <= '0;
         op_b_q      <= '0;
         div_go_q    <= 1'b0;
         total_q     <= '0;
         srch_init_q <= 1'b0;
         done_o      <= 1'b0;
         err_o       <= 1'b0;
         timing_o    <= '0;
      end else begin
         div_go_q    <= 1'b0;
         srch_init_q <= 1'b0;
         done_o      <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  freq_q <= clk_hz_i;
                  baud_q <= baud_i;
                  if (baud_i == '0) begin
                     err_o    <= 1'b1;
                     timing_o <= '0;
                     done_o   <= 1'b1;
                  end else begin
                     op_a_q   <= {1'b0, clk_hz_i};
                     op_b_q   <= DIV_W'(3);
                     div_go_q <= 1'b1;
                     phase_q  <= PH_DIV3;
                  end
               end
            end
            PH_DIV3: begin
               if (div_done) begin
                  op_a_q   <= quot;
                  op_b_q   <= {1'b0, baud_q};
                  div_go_q <= 1'b1;
                  phase_q  <= PH_DIVB;
               end
            end
            PH_DIVB: begin
               if (div_done) begin
                  total_q     <= $signed({1'b0, quot}) - $signed(TOT_W'(1));
                  srch_init_q <= 1'b1;
                  phase_q     <= PH_SRCH;
               end
            end
            PH_SRCH: begin
               if (!srch_init_q && srch_fin) begin
                  if (!srch_found) begin
                     err_o    <= 1'b1;
                     timing_o <= '0;
                     done_o   <= 1'b1;
                     phase_q  <= PH_IDLE;
                  end else begin
                     op_a_q   <= {1'b0, freq_q};
                     op_b_q   <= DIV_W'(s1_best) + DIV_W'(s2_best) + DIV_W'(1);
                     div_go_q <= 1'b1;
                     phase_q  <= PH_DIVN;
                  end
               end
            end
            PH_DIVN: begin
               if (div_done) begin
                  op_a_q   <= quot + {1'b0, baud_q} - DIV_W'(1);
                  op_b_q   <= {1'b0, baud_q};
                  div_go_q <= 1'b1;
                  phase_q  <= PH_DIVR;
               end
            end
            PH_DIVR: begin
               if (div_done) begin
                  if (pre_bad) begin
                     err_o    <= 1'b1;
                     timing_o <= '0;
                  end else begin
                     err_o    <= 1'b0;
                     timing_o <= word_n;
                  end
                  done_o  <= 1'b1;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o = (phase_q != PH_IDLE);

endmodule

// File: rtl/bt_solver_chk.sv
module bt_solver_chk #(
   parameter int unsigned FREQ_W = 32,
   parameter int unsigned WORD_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [FREQ_W-1:0] baud_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [WORD_W-1:0] timing_o
);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R8
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(timing_o) && $stable(err_o)));

   // R7
   zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && baud_i == '0) |=> (done_o && err_o && !busy_o));

   // R9
   busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R11
   err_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (timing_o == '0));

endmodule

bind bt_timing_solver bt_solver_chk #(
   .FREQ_W (FREQ_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .baud_i   (baud_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .err_o    (err_o),
   .timing_o (timing_o)
);

// File: tb/bt_timing_solver_tb.sv
module bt_timing_solver_tb_top;
   localparam int CLK_P   = 10;
   localparam int PRE_LIM = 3;     // tight limit so R6 overflow is reachable
   localparam int WORD_W  = 19;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [31:0]       clk_hz = '0;
   logic [31:0]       baud = '0;
   logic              busy, done, err;
   logic [WORD_W-1:0] word;

   int n_chk = 0;
   int n_err = 0;

   bit      pending = 0;
   longint  exp_word = 0, nxt_word = 0;
   bit      exp_err = 0, nxt_err = 0;
   longint  nxt_rate = 0;
   int      lat = 0;
   string   cur_req = "R1";

   always #(CLK_P/2) clk = ~clk;

   bt_timing_solver #(.PRE_MAX(PRE_LIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .clk_hz_i(clk_hz),
      .baud_i(baud), .busy_o(busy), .done_o(done), .err_o(err), .timing_o(word)
   );

   // Behavioural model of the solve (R3 R4 R5 R6 R2)
   function automatic void ref_solve(input longint f, input longint b,
                                     output longint w, output bit e);
      longint total, s2, d, best_d, s1b, s2b, q, pre;
      w = 0; e = 1;
      if (b == 0) return;
      total = (f / 3) / b - 1;
      best_d = 16; s1b = 17; s2b = 0;
      for (int c = 1; c <= 16; c++) begin
         s2 = total - c;
         if (s2 < 1) break;
         if (s2 <= 8) begin
            d = (c > s2) ? c - s2 : s2 - c;
            if (d < best_d) begin best_d = d; s1b = c; s2b = s2; end
         end
      end
      if (s1b > 16) return;
      q   = f / (s1b + s2b + 1);
      pre = (q + b - 1) / b;
      if (pre == 0 || pre > PRE_LIM) return;
      e = 0;
      w = (pre - 1) | ((s1b - 1) << 10) | ((s2b - 1) << 14);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Per-clock comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (pending) lat++;
         if (done) begin
            check(pending, {cur_req, " unexpected done"}, 1, 0);
            if (pending) begin
               check(err == nxt_err, {cur_req, " err"}, err, nxt_err);
               check(word == nxt_word[WORD_W-1:0], {cur_req, " word"}, word, nxt_word);
               check(!busy, "R8 busy at done", busy, 0);
               if (nxt_rate == 0) check(lat == 1, "R7 latency", lat, 1);
               exp_word = nxt_word; exp_err = nxt_err; pending = 0;
            end
         end else if (!pending) begin
            check(!busy, "R8 busy while idle", busy, 0);
            check(word == exp_word[WORD_W-1:0], "R8 word hold", word, exp_word);
            check(err == exp_err, "R8 err hold", err, exp_err);
         end else if (lat > 400) begin
            check(0, {cur_req, " no done"}, lat, 400);
            pending = 0;
         end
         if (done) begin
            @(posedge clk); #1;
            check(!done, "R8 done width", done, 0);
         end
      end
   end

   task automatic run(input longint f, input longint b, input string req,
                      input bit poke = 0);
      longint w; bit e;
      wait (!pending);
      @(negedge clk);
      ref_solve(f, b, w, e);
      nxt_word = w; nxt_err = e; nxt_rate = b; cur_req = req; lat = 0;
      clk_hz = 32'(f); baud = 32'(b); start = 1'b1; pending = 1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R9: a second start while busy must change nothing
         repeat (5) @(negedge clk);
         check(busy, "R9 busy before poke", busy, 1);
         clk_hz = 32'd6; baud = 32'd0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (!pending);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !err, "R1 flags in reset", {busy, done, err}, 0);
      check(word == '0, "R1 word in reset", word, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !err && word == '0, "R1 after reset", word, 0);

      run(42_000_000, 1_000_000, "R10");
      check(word == 103426, "R10 literal word", word, 103426);
      check(word[18:17] == 2'd0, "R2 jump width field", word[18:17], 0);
      run(27_000_000, 1_000_000, "R4");
      run(75, 1, "R3");           // largest legal total: 16/8
      run(78, 1, "R5");           // every second segment above 8
      run(9, 1, "R3");            // smallest total: 1/1
      run(6, 1, "R5");            // stops at the first candidate
      run(100_000_000, 10_000, "R5");
      run(8_000_000, 500_000, "R6");   // prescaler 4 over the limit
      run(42_000_000, 0, "R7");
      check(err && word == '0, "R11 zero word on error", word, 0);
      run(42_000_000, 1_000_000, "R9", 1);
      run(12_000_000, 1_000_000, "R4");
      run(33, 1, "R4");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100_000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule